// File: doc/BRIEF.md
# Six-Instruction Single-Cycle Core

A small load/store processor that fetches, decodes and completes one instruction per clock. The subset it understands is register add, add with immediate, word load, word store, branch when two registers are equal, and an absolute jump. Every other instruction word passes through as a no-op. Program storage and data storage are two separate word arrays held inside the block. The surrounding environment fills the program array before reset is released.

The datapath is built from a few parts:

- a program counter with its own +4 adder;
- a 32-entry by 32-bit register file with two combinational read ports and one write port that commits on the clock edge;
- a 16-to-32 sign extender;
- an adder-based ALU with an equality compare;
- a decoder that turns the instruction into one-hot form and derives the named control signals from it;
- four selectors, for the destination index, the second ALU operand, the write-back value and the next PC.

The only outputs are debug taps. They show the current PC and the register write that the next rising edge will commit.

Top module: `tiny6_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0. While reset is high, neither the register file nor data memory is written and `dbg_wr_en` is low. The first instruction after reset is fetched from address 0.
- R2: An instruction that is not a jump and not a taken branch advances the PC by exactly 4.
- R3: Instruction fields sit at these positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0]. Opcode 0x00 with funct 0x20 writes rs+rt into register rd.
- R4: Opcode 0x08 writes rs plus the immediate into register rt. The immediate is sign-extended from bit 15.
- R5: Opcode 0x23 loads the data word at byte address rs+sext(imm) into register rt. Word index = address[AW+1:2].
- R6: Opcode 0x2B stores register rt to data word rs+sext(imm) and writes no register.
- R7: Opcode 0x04 compares rs with rt. When they are equal, the next PC is PC+4+(sext(imm)<<2). Otherwise the next PC is PC+4. No register write takes place in either case.
- R8: Opcode 0x02 sets the next PC to {PC+4[31:28], insn[25:0], 2'b00} and writes nothing.
- R9: Register 0 always reads as zero. A write aimed at it is still shown on the debug port but leaves it at zero.
- R10: Any other opcode, and opcode 0x00 with any funct other than 0x20, writes nothing and advances the PC by 4.
- R11: `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` show, during a cycle, the register write committed at that cycle's closing rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register write commits at the next rising edge |
| dbg_wr_idx | output | 5 | Destination register index of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The hardest case to reach from the ports is a store followed by a load of the same word. Data memory has no output port, so the only evidence that a store landed is the value a later load brings back. The test program therefore stores a positive and a sign-extended negative value at two addresses formed with different base registers and offsets. It then reads both back and checks the write-back traffic on the debug port. The same program also steers control flow past code that must not run: a not-taken branch, a taken forward branch, a jump over two words and a backward branch to itself. The expected PC sequence therefore also proves that the skipped instructions never issued.

// File: rtl/tiny6_pkg.sv
package tiny6_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);
    localparam int IMM_W     = 16;
    localparam int JTGT_W    = 26;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] FN_ADD   = 6'h20;

    typedef enum int {
        K_ADD   = 0,
        K_ADDI  = 1,
        K_LOAD  = 2,
        K_STORE = 3,
        K_BEQ   = 4,
        K_JUMP  = 5
    } kind_e;

    localparam int NKINDS = 6;

    typedef struct packed {
        logic [5:0]        opcode;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
        logic [IMM_W-1:0]  imm;
        logic [JTGT_W-1:0] jtgt;
    } fields_t;

    typedef struct packed {
        logic reg_we;     // write the register file
        logic dst_is_rd;  // destination from rd, otherwise rt
        logic alub_imm;   // second ALU operand is the extended immediate
        logic wb_mem;     // write-back from data memory, otherwise ALU
        logic mem_we;     // write data memory
        logic is_beq;
        logic is_jmp;
    } ctrl_t;

    function automatic fields_t split_insn(input logic [XLEN-1:0] w);
        fields_t f;
        f.opcode = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.shamt  = w[10:6];
        f.funct  = w[5:0];
        f.imm    = w[15:0];
        f.jtgt   = w[25:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] seq_pc,
                                                    input logic [JTGT_W-1:0] t);
        return {seq_pc[XLEN-1:XLEN-4], t, 2'b00};
    endfunction

endpackage

// File: rtl/tiny6_mem.sv
module tiny6_mem #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             we,
    input  logic [WIDTH-1:0] byte_addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] cells [DEPTH];
    logic [AW-1:0]    idx;

    assign idx   = byte_addr[AW+1:2];
    assign rdata = cells[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
    end
endmodule

// File: rtl/tiny6_regfile.sv
module tiny6_regfile
    import tiny6_pkg::*;
#(
    parameter int WIDTH = XLEN,
    parameter int COUNT = REG_COUNT
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(COUNT)-1:0] wa,
    input  logic [WIDTH-1:0]         wd,
    input  logic [$clog2(COUNT)-1:0] ra_a,
    output logic [WIDTH-1:0]         rd_a,
    input  logic [$clog2(COUNT)-1:0] ra_b,
    output logic [WIDTH-1:0]         rd_b
);
    localparam int IW = $clog2(COUNT);

    logic [WIDTH-1:0] regs [COUNT];

    always_ff @(posedge clk) begin
        if (we && (wa != IW'(0))) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == IW'(0)) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == IW'(0)) ? '0 : regs[ra_b];
endmodule

// File: rtl/tiny6_decode.sv
module tiny6_decode
    import tiny6_pkg::*;
(
    input  fields_t           f,
    output logic [NKINDS-1:0] kind_oh,
    output ctrl_t             ctl
);
    always_comb begin
        kind_oh          = '0;
        kind_oh[K_ADD]   = (f.opcode == OP_RTYPE) && (f.funct == FN_ADD);
        kind_oh[K_ADDI]  = (f.opcode == OP_ADDI);
        kind_oh[K_LOAD]  = (f.opcode == OP_LOAD);
        kind_oh[K_STORE] = (f.opcode == OP_STORE);
        kind_oh[K_BEQ]   = (f.opcode == OP_BEQ);
        kind_oh[K_JUMP]  = (f.opcode == OP_JUMP);

        ctl.reg_we    = kind_oh[K_ADD] | kind_oh[K_ADDI] | kind_oh[K_LOAD];
        ctl.dst_is_rd = kind_oh[K_ADD];
        ctl.alub_imm  = kind_oh[K_ADDI] | kind_oh[K_LOAD] | kind_oh[K_STORE];
        ctl.wb_mem    = kind_oh[K_LOAD];
        ctl.mem_we    = kind_oh[K_STORE];
        ctl.is_beq    = kind_oh[K_BEQ];
        ctl.is_jmp    = kind_oh[K_JUMP];
    end
endmodule

// File: rtl/tiny6_alu.sv
module tiny6_alu
    import tiny6_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] cmp,
    output logic [XLEN-1:0] sum,
    output logic            equal
);
    assign sum   = opa + opb;
    assign equal = (opa == cmp);
endmodule

// File: rtl/tiny6_core.sv
module tiny6_core
    import tiny6_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wr_en,
    output logic [RIDX_W-1:0] dbg_wr_idx,
    output logic [XLEN-1:0]   dbg_wr_data
);
    logic [XLEN-1:0]   pc_q, pc_seq, pc_br, pc_next;
    logic [XLEN-1:0]   insn;
    fields_t           fields;
    ctrl_t             ctl;
    logic [NKINDS-1:0] kind_oh;
    logic [XLEN-1:0]   rs_val, rt_val, imm_x, alu_b, alu_sum, dm_rdata, wb_val;
    logic              rs_eq;
    logic [RIDX_W-1:0] dst_idx;
    logic              rf_we, dm_we;

    // fetch
    assign pc_seq = pc_q + XLEN'(4);

    tiny6_mem #(.WIDTH(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
        .clk(clk), .we(1'b0), .byte_addr(pc_q), .wdata('0), .rdata(insn)
    );

    // decode
    assign fields = split_insn(insn);

    tiny6_decode u_dec (.f(fields), .kind_oh(kind_oh), .ctl(ctl));

    assign rf_we = ctl.reg_we & ~rst;
    assign dm_we = ctl.mem_we & ~rst;

    tiny6_regfile #(.WIDTH(XLEN), .COUNT(REG_COUNT)) u_rf (
        .clk(clk), .we(rf_we), .wa(dst_idx), .wd(wb_val),
        .ra_a(fields.rs), .rd_a(rs_val), .ra_b(fields.rt), .rd_b(rt_val)
    );

    // execute
    assign imm_x   = sext16(fields.imm);
    assign alu_b   = ctl.alub_imm ? imm_x : rt_val;
    assign dst_idx = ctl.dst_is_rd ? fields.rd : fields.rt;

    tiny6_alu u_alu (.opa(rs_val), .opb(alu_b), .cmp(rt_val), .sum(alu_sum), .equal(rs_eq));

    // memory and write-back
    tiny6_mem #(.WIDTH(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk(clk), .we(dm_we), .byte_addr(alu_sum), .wdata(rt_val), .rdata(dm_rdata)
    );

    assign wb_val = ctl.wb_mem ? dm_rdata : alu_sum;

    // next PC
    assign pc_br = pc_seq + {imm_x[XLEN-3:0], 2'b00};

    always_comb begin
        if (ctl.is_jmp) begin
            pc_next = jump_target(pc_seq, fields.jtgt);
        end else if (ctl.is_beq && rs_eq) begin
            pc_next = pc_br;
        end else begin
            pc_next = pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign dbg_pc      = pc_q;
    assign dbg_wr_en   = rf_we;
    assign dbg_wr_idx  = dst_idx;
    assign dbg_wr_data = wb_val;
endmodule

// File: rtl/tiny6_core_chk.sv
module tiny6_core_chk
    import tiny6_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic [5:0]        opcode,
    input logic [5:0]        funct,
    input logic [RIDX_W-1:0] rs_idx,
    input logic [XLEN-1:0]   rs_val,
    input logic              rs_eq,
    input logic [NKINDS-1:0] kind_oh,
    input ctrl_t             ctl,
    input logic              dm_we,
    input logic              wr_en
);
    assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0));

    assert_no_write_in_reset_R1: assert property (@(posedge clk)
        rst |-> (!wr_en && !dm_we));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.is_jmp) && !($past(ctl.is_beq) && $past(rs_eq)))
        |-> (pc == $past(pc) + XLEN'(4)));

    assert_onehot_decode_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(kind_oh));

    assert_store_only_R6: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> ((opcode == OP_STORE) && !wr_en));

    assert_pc_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    assert_reg_we_legal_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((opcode == OP_ADDI) || (opcode == OP_LOAD) ||
                   ((opcode == OP_RTYPE) && (funct == FN_ADD))));

    always_comb begin
        if (!rst && rs_idx == '0) begin
            assert_zero_reg_R9: assert (rs_val == '0);
        end
    end
endmodule

bind tiny6_core tiny6_core_chk u_chk (
    .clk(clk), .rst(rst), .pc(pc_q), .opcode(fields.opcode), .funct(fields.funct),
    .rs_idx(fields.rs), .rs_val(rs_val), .rs_eq(rs_eq), .kind_oh(kind_oh),
    .ctl(ctl), .dm_we(dm_we), .wr_en(rf_we)
);

// File: tb/tiny6_core_test.sv
module tiny6_core_test;
    import tiny6_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 22;

    typedef struct {
        int    idx;
        int    data;
        string req;
    } wr_item_t;

    typedef struct {
        int    pc;
        string req;
    } pc_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [XLEN-1:0]   dbg_pc;
    logic              dbg_wr_en;
    logic [RIDX_W-1:0] dbg_wr_idx;
    logic [XLEN-1:0]   dbg_wr_data;

    int       n_run  = 0;
    int       n_fail = 0;
    bit       done   = 1'b0;
    wr_item_t wr_q[$];
    pc_item_t pc_q[$];

    tiny6_core uut (
        .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
        .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] enc_add(int rd, int rs, int rt, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic push_wr(int idx, int data, string req);
        wr_item_t it;
        it.idx = idx; it.data = data; it.req = req;
        wr_q.push_back(it);
    endtask

    task automatic push_pc(int pc, string req);
        pc_item_t it;
        it.pc = pc; it.req = req;
        pc_q.push_back(it);
    endtask

    // driver: loads the program and queues what the ports must show
    task automatic drive_program();
        logic [31:0] prog [20];
        prog[0]  = enc_i(8'h08, 1, 0, 5);         // addi r1 = 5
        prog[1]  = enc_i(8'h08, 2, 0, -3);        // addi r2 = -3
        prog[2]  = enc_add(3, 1, 2, 8'h20);       // add r3 = r1 + r2 = 2
        prog[3]  = enc_i(8'h08, 0, 1, 7);         // addi r0 = 12 (discarded)
        prog[4]  = enc_add(4, 0, 0, 8'h20);       // add r4 = r0 + r0
        prog[5]  = enc_i(8'h2B, 1, 3, 6);         // store r1 -> 8
        prog[6]  = enc_i(8'h23, 5, 0, 8);         // load r5 <- 8
        prog[7]  = enc_i(8'h2B, 2, 0, 12);        // store r2 -> 12
        prog[8]  = enc_i(8'h23, 6, 3, 10);        // load r6 <- 12
        prog[9]  = enc_i(8'h04, 2, 1, 5);         // beq r1,r2 not taken
        prog[10] = enc_i(8'h04, 1, 5, 2);         // beq r5,r1 taken -> 52
        prog[11] = enc_i(8'h08, 7, 0, 99);
        prog[12] = enc_i(8'h08, 7, 0, 98);
        prog[13] = {6'h02, 26'd16};               // jump -> 64
        prog[14] = enc_i(8'h08, 7, 0, 97);
        prog[15] = enc_i(8'h08, 7, 0, 96);
        prog[16] = enc_add(8, 3, 3, 8'h20);       // add r8 = 4
        prog[17] = enc_add(9, 1, 1, 8'h22);       // other funct: no-op
        prog[18] = {6'h3F, 26'h0123456};          // unknown opcode: no-op
        prog[19] = enc_i(8'h04, 0, 0, -1);        // beq to itself
        for (int i = 0; i < 64; i++) begin
            uut.u_imem.cells[i] = (i < 20) ? prog[i] : 32'h0;
        end

        push_wr(1, 5, "R4");
        push_wr(2, 32'hFFFFFFFD, "R4");
        push_wr(3, 2, "R3");
        push_wr(0, 12, "R9");
        push_wr(4, 0, "R9");
        push_wr(5, 5, "R6");
        push_wr(6, 32'hFFFFFFFD, "R5");
        push_wr(8, 4, "R8");

        push_pc(0, "R1");
        for (int a = 4; a <= 36; a += 4) push_pc(a, "R2");
        push_pc(40, "R7");
        push_pc(52, "R7");
        push_pc(64, "R8");
        push_pc(68, "R10");
        push_pc(72, "R10");
        for (int k = 0; k < 6; k++) push_pc(76, "R7");
    endtask

    // monitor: one sample per cycle, away from the rising edge
    task automatic monitor_run(int cycles);
        for (int c = 0; c < cycles; c++) begin
            #1;
            if (pc_q.size() > 0) begin
                pc_item_t p = pc_q.pop_front();
                check(dbg_pc == 32'(p.pc), p.req, "pc", dbg_pc, p.pc);
            end
            if (dbg_wr_en) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected register write idx", int'(dbg_wr_idx), -1);
                end else begin
                    wr_item_t w = wr_q.pop_front();
                    check(int'(dbg_wr_idx) == w.idx, w.req, "write index", int'(dbg_wr_idx), w.idx);
                    check(dbg_wr_data == 32'(w.data), w.req, "write data (R11)", dbg_wr_data, w.data);
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        drive_program();
        repeat (3) @(negedge clk);
        #1;
        check(dbg_pc == 32'h0, "R1", "pc in reset", dbg_pc, 0);
        check(!dbg_wr_en, "R1", "write enable in reset", int'(dbg_wr_en), 0);
        @(negedge clk);
        rst = 1'b0;
        monitor_run(RUN_CYCLES);
        check(wr_q.size() == 0, "R11", "writes left unseen", wr_q.size(), 0);
        check(pc_q.size() == 0, "R2", "pc items left unseen", pc_q.size(), 0);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(dbg_pc == 32'h0, "R1", "pc after second reset", dbg_pc, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule